// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block sits between an instruction decoder and a floating-point arithmetic unit. It takes one three-operand floating-point operation and turns it into a series of element operations. The operation arrives as a destination register number and two source register numbers, a precision select, and the current short-vector length and stride settings. The block decides whether the operation is scalar, mixed scalar/vector or full vector. It then presents one element operation at a time on a valid/ready handshake.

Between elements, each register number that advances moves forward inside its own bank. It wraps within the bank and never leaves it. A second source that sits in bank 0 is treated as a scalar and is held fixed while the other two operands advance. The block also rejects operations that the configured capabilities do not allow, and it signals this with an undefined pulse. The arithmetic, the register file and all rounding are outside the block.

Top module: `vecop_issue_seq`

## Requirements
- R1: After reset, elem_valid, done and undef are all low.
- R2: If len is 0, or the destination lies in bank 0, exactly one element is issued, with rd=vd, rn=vn and rm=vm. The destination bank is vd[4:3] in single precision (dp=0) and vd[3:2] in double precision (dp=1).
- R3: A sequence that is not scalar issues len+1 elements. Each element is one handshake, where elem_valid and elem_ready are both high at a rising edge.
- R4: In single precision, rd and rn advance by stride+1 between elements. Bits [4:3] are kept, and bits [2:0] wrap modulo 8.
- R5: In double precision, rd and rn advance by (stride>>1)+1 between elements. Bits [4:2] are kept, and bits [1:0] wrap modulo 4.
- R6: If the destination bank is nonzero and the bank of vm is 0 (same bit positions as R2), rm stays equal to vm on every element. Otherwise rm advances exactly like rd.
- R7: If fpshvec is 0 and len or stride is nonzero, undef pulses and no element is issued.
- R8: If dp is 1, d32 is 0 and any of vd, vn or vm has bit 4 set, undef pulses and no element is issued.
- R9: read_vd is high on every element exactly when reads_vd was high at start.
- R10: While elem_valid is high and elem_ready is low, elem_valid, rd, rn, rm and read_vd hold their values.
- R11: A start while a sequence is running is ignored, and the sequence in progress continues unchanged.
- R12: elem_valid rises in the cycle after an accepted start. done is a one-cycle pulse in the cycle after the last handshake, and elem_valid is low in that cycle. undef is a one-cycle pulse in the cycle after a rejected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| vd | input | 5 | Destination register number |
| vn | input | 5 | First source register number |
| vm | input | 5 | Second source register number |
| dp | input | 1 | 1 = double precision, 0 = single |
| len | input | 3 | Vector length setting (elements minus one) |
| stride | input | 2 | Vector stride setting |
| fpshvec | input | 1 | Short-vector capability present |
| d32 | input | 1 | Upper 16 double registers present |
| reads_vd | input | 1 | Operation accumulates into the destination |
| elem_valid | output | 1 | An element operation is presented |
| elem_ready | input | 1 | Arithmetic unit accepts the element |
| rd | output | 5 | Current destination register number |
| rn | output | 5 | Current first source register number |
| rm | output | 5 | Current second source register number |
| read_vd | output | 1 | Element must read the old destination |
| undef | output | 1 | Operation rejected as undefined (pulse) |
| done | output | 1 | Sequence completed (pulse) |

## Verification
The main sweep crosses both precisions, every length and every stride with four register triples. These triples are chosen to separate four cases: a bank-0 destination (scalar), a bank-0 second source (mixed, rm must stay fixed), full-vector operands that wrap past the top of their bank, and double-precision numbers whose bit 4 must survive stepping. Ready is throttled in a repeating pattern, so every sequence is also checked for holding its outputs across stalls. A second sweep disables each capability in turn, to separate legal scalar requests from rejected ones. Some sequences receive a stray start while they are running, to show that it does not disturb them.

// File: rtl/vecop_pkg.sv
package vecop_pkg;
  parameter int REG_W    = 5;
  parameter int LEN_W    = 3;
  parameter int STRIDE_W = 2;
  localparam int INC_W   = STRIDE_W + 1;

  typedef enum logic [1:0] {
    KIND_SCALAR = 2'd0,
    KIND_MIXED  = 2'd1,
    KIND_VECTOR = 2'd2
  } vec_kind_e;
endpackage

// File: rtl/vecop_classify.sv
module vecop_classify
  import vecop_pkg::*;
(
  input  logic [REG_W-1:0]    vd,
  input  logic [REG_W-1:0]    vn,
  input  logic [REG_W-1:0]    vm,
  input  logic                dp,
  input  logic [LEN_W-1:0]    len,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                fpshvec,
  input  logic                d32,
  output logic                reject,
  output vec_kind_e           kind,
  output logic [INC_W-1:0]    inc,
  output logic [LEN_W-1:0]    count_m1
);
  localparam int SP_LOW = REG_W - 2;
  localparam int DP_LOW = REG_W - 3;

  logic [1:0] bank_d, bank_m;
  logic       hi_any;

  always_comb begin
    bank_d = dp ? vd[DP_LOW +: 2] : vd[SP_LOW +: 2];
    bank_m = dp ? vm[DP_LOW +: 2] : vm[SP_LOW +: 2];
    hi_any = vd[REG_W-1] | vn[REG_W-1] | vm[REG_W-1];

    reject = 1'b0;
    if (!fpshvec && ((len != '0) || (stride != '0))) reject = 1'b1;
    if (dp && !d32 && hi_any)                        reject = 1'b1;

    if ((len == '0) || (bank_d == 2'b00)) kind = KIND_SCALAR;
    else if (bank_m == 2'b00)             kind = KIND_MIXED;
    else                                  kind = KIND_VECTOR;

    count_m1 = (kind == KIND_SCALAR) ? '0 : len;

    if (dp) inc = INC_W'({1'b0, stride[STRIDE_W-1:1]}) + INC_W'(1);
    else    inc = INC_W'(stride) + INC_W'(1);
  end
endmodule

// File: rtl/vecop_reg_step.sv
module vecop_reg_step
  import vecop_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             dp,
  input  logic             adv,
  input  logic [INC_W-1:0] inc,
  output logic [REG_W-1:0] nxt
);
  localparam int SP_LOW = REG_W - 2;
  localparam int DP_LOW = REG_W - 3;

  logic [SP_LOW-1:0] sp_low;
  logic [DP_LOW-1:0] dp_low;

  always_comb begin
    sp_low = cur[SP_LOW-1:0] + SP_LOW'(inc);
    dp_low = cur[DP_LOW-1:0] + DP_LOW'(inc);
    if (!adv)    nxt = cur;
    else if (dp) nxt = {cur[REG_W-1:DP_LOW], dp_low};
    else         nxt = {cur[REG_W-1:SP_LOW], sp_low};
  end
endmodule

// File: rtl/vecop_ctrl.sv
module vecop_ctrl
  import vecop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] vd,
  input  logic [REG_W-1:0] vn,
  input  logic [REG_W-1:0] vm,
  input  logic             dp,
  input  logic             reads_vd,
  input  logic             reject,
  input  vec_kind_e        kind,
  input  logic [INC_W-1:0] inc,
  input  logic [LEN_W-1:0] count_m1,
  input  logic [REG_W-1:0] rd_step,
  input  logic [REG_W-1:0] rn_step,
  input  logic [REG_W-1:0] rm_step,
  input  logic             elem_ready,
  output logic             busy_q,
  output logic [REG_W-1:0] rd_q,
  output logic [REG_W-1:0] rn_q,
  output logic [REG_W-1:0] rm_q,
  output logic             rm_adv_q,
  output logic             dp_q,
  output logic [INC_W-1:0] inc_q,
  output logic             rdv_q,
  output logic             done_q,
  output logic             undef_q
);
  logic             accept, fire, last;
  logic             busy_d, done_d, undef_d, load, step;
  logic [LEN_W-1:0] left_q, left_d;

  always_comb begin
    accept  = start && !busy_q;
    fire    = busy_q && elem_ready;
    last    = (left_q == '0);
    load    = accept && !reject;
    step    = fire && !last;
    busy_d  = busy_q;
    left_d  = left_q;
    done_d  = 1'b0;
    undef_d = accept && reject;
    if (load) begin
      busy_d = 1'b1;
      left_d = count_m1;
    end else if (fire) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        left_d = left_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      left_q  <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      left_q  <= left_d;
      done_q  <= done_d;
      undef_q <= undef_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= '0;
      rn_q     <= '0;
      rm_q     <= '0;
      rm_adv_q <= 1'b0;
      dp_q     <= 1'b0;
      inc_q    <= '0;
      rdv_q    <= 1'b0;
    end else if (load) begin
      rd_q     <= vd;
      rn_q     <= vn;
      rm_q     <= vm;
      rm_adv_q <= (kind == KIND_VECTOR);
      dp_q     <= dp;
      inc_q    <= inc;
      rdv_q    <= reads_vd;
    end else if (step) begin
      rd_q <= rd_step;
      rn_q <= rn_step;
      rm_q <= rm_step;
    end
  end
endmodule

// File: rtl/vecop_issue_seq.sv
module vecop_issue_seq
  import vecop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [REG_W-1:0]    vd,
  input  logic [REG_W-1:0]    vn,
  input  logic [REG_W-1:0]    vm,
  input  logic                dp,
  input  logic [LEN_W-1:0]    len,
  input  logic [STRIDE_W-1:0] stride,
  input  logic                fpshvec,
  input  logic                d32,
  input  logic                reads_vd,
  output logic                elem_valid,
  input  logic                elem_ready,
  output logic [REG_W-1:0]    rd,
  output logic [REG_W-1:0]    rn,
  output logic [REG_W-1:0]    rm,
  output logic                read_vd,
  output logic                undef,
  output logic                done
);
  localparam int NOPS = 3;

  logic             reject;
  vec_kind_e        kind;
  logic [INC_W-1:0] inc;
  logic [LEN_W-1:0] count_m1;
  logic             busy_q, rm_adv_q, dp_q, rdv_q, done_q, undef_q;
  logic [INC_W-1:0] inc_q;
  logic [REG_W-1:0] rd_q, rn_q, rm_q;
  logic [REG_W-1:0] cur_v [NOPS];
  logic [REG_W-1:0] nxt_v [NOPS];
  logic             adv_v [NOPS];

  vecop_classify u_cls (
    .vd(vd), .vn(vn), .vm(vm), .dp(dp), .len(len), .stride(stride),
    .fpshvec(fpshvec), .d32(d32), .reject(reject), .kind(kind),
    .inc(inc), .count_m1(count_m1)
  );

  vecop_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vd(vd), .vn(vn), .vm(vm),
    .dp(dp), .reads_vd(reads_vd), .reject(reject), .kind(kind), .inc(inc),
    .count_m1(count_m1), .rd_step(nxt_v[0]), .rn_step(nxt_v[1]),
    .rm_step(nxt_v[2]), .elem_ready(elem_ready), .busy_q(busy_q),
    .rd_q(rd_q), .rn_q(rn_q), .rm_q(rm_q), .rm_adv_q(rm_adv_q),
    .dp_q(dp_q), .inc_q(inc_q), .rdv_q(rdv_q), .done_q(done_q),
    .undef_q(undef_q)
  );

  always_comb begin
    cur_v[0] = rd_q;  adv_v[0] = 1'b1;
    cur_v[1] = rn_q;  adv_v[1] = 1'b1;
    cur_v[2] = rm_q;  adv_v[2] = rm_adv_q;
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_step
    vecop_reg_step u_step (
      .cur(cur_v[g]), .dp(dp_q), .adv(adv_v[g]), .inc(inc_q), .nxt(nxt_v[g])
    );
  end

  assign elem_valid = busy_q;
  assign rd         = rd_q;
  assign rn         = rn_q;
  assign rm         = rm_q;
  assign read_vd    = busy_q && rdv_q;
  assign undef      = undef_q;
  assign done       = done_q;
endmodule

module vecop_issue_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       elem_valid,
  input logic       elem_ready,
  input logic [4:0] rd,
  input logic [4:0] rn,
  input logic [4:0] rm,
  input logic       read_vd,
  input logic       undef,
  input logic       done,
  input logic       dp_q
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && !elem_ready |=> elem_valid && $stable(rd) && $stable(rn)
                                  && $stable(rm) && $stable(read_vd));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_undef_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> !undef);

  p_undef_no_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !elem_valid && !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_valid);

  p_bank_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && $past(elem_valid && elem_ready) && !dp_q
      |-> rd[4:3] == $past(rd[4:3]) && rn[4:3] == $past(rn[4:3]));

  p_bank_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid && $past(elem_valid && elem_ready) && dp_q
      |-> rd[4:2] == $past(rd[4:2]) && rn[4:2] == $past(rn[4:2]));
endmodule

bind vecop_issue_seq vecop_issue_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_ready(elem_ready),
  .rd(rd), .rn(rn), .rm(rm), .read_vd(read_vd), .undef(undef), .done(done),
  .dp_q(dp_q)
);

// File: tb/vecop_issue_seq_tb.sv
module vecop_issue_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] vd = '0, vn = '0, vm = '0;
  logic       dp = 1'b0;
  logic [2:0] len = '0;
  logic [1:0] stride = '0;
  logic       fpshvec = 1'b1, d32 = 1'b1, reads_vd = 1'b0;
  logic       elem_ready = 1'b0;
  logic       elem_valid, read_vd, undef, done;
  logic [4:0] rd, rn, rm;

  int n_tests = 0;
  int n_fail  = 0;
  int phase   = 0;
  bit timed_out = 0;

  always #10 clk = ~clk;

  vecop_issue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vd(vd), .vn(vn), .vm(vm),
    .dp(dp), .len(len), .stride(stride), .fpshvec(fpshvec), .d32(d32),
    .reads_vd(reads_vd), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .rd(rd), .rn(rn), .rm(rm), .read_vd(read_vd), .undef(undef), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] step_reg(input logic [4:0] r, input bit d,
                                          input int inc);
    if (d) return {r[4:2], 2'((int'(r[1:0]) + inc) % 4)};
    return {r[4:3], 3'((int'(r[2:0]) + inc) % 8)};
  endfunction

  task automatic run_op(input bit d, input int l, input int s,
                        input logic [4:0] a, input logic [4:0] b,
                        input logic [4:0] c, input bit sh, input bit h32,
                        input bit rv, input bit inj);
    int bd, bm, cnt, inc, idx, guard;
    bit exp_undef, scalar, mixed, last_rdy, r;
    logic [4:0] er, en, em;
    string tag;
    bd = d ? int'(a[3:2]) : int'(a[4:3]);
    bm = d ? int'(c[3:2]) : int'(c[4:3]);
    exp_undef = (!sh && (l != 0 || s != 0)) || (d && !h32 && ((a | b | c) & 5'h10) != 0);
    scalar = (l == 0) || (bd == 0);
    mixed  = !scalar && (bm == 0);
    cnt    = scalar ? 1 : l + 1;
    inc    = d ? (s >> 1) + 1 : s + 1;
    if (inj)         tag = "R11";
    else if (scalar) tag = "R2";
    else if (mixed)  tag = "R6";
    else if (d)      tag = "R5";
    else             tag = "R4";

    @(negedge clk);
    vd = a; vn = b; vm = c; dp = d; len = 3'(l); stride = 2'(s);
    fpshvec = sh; d32 = h32; reads_vd = rv; start = 1'b1; elem_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (exp_undef) begin
      check(undef && !elem_valid, h32 ? "R7" : "R8", "undef pulse",
            int'({undef, elem_valid}), 2);
      @(negedge clk);
      check(!undef && !elem_valid && !done, "R12", "undef one cycle",
            int'({undef, elem_valid, done}), 0);
      return;
    end
    er = a; en = b; em = c; idx = 0; guard = 0; last_rdy = 1'b1;
    while (idx < cnt && guard < 200) begin
      check(elem_valid && rd == er && rn == en && rm == em,
            last_rdy ? tag : "R10", "element regs",
            int'({elem_valid, rd, rn, rm}), int'({1'b1, er, en, em}));
      check(read_vd == rv, "R9", "read_vd strobe", int'(read_vd), int'(rv));
      if (inj && guard == 1) begin
        start = 1'b1; vd = ~a; vn = ~b; vm = ~c; len = 3'd0;
      end else begin
        start = 1'b0;
      end
      phase++;
      r = (phase % 4) != 3;
      elem_ready = r;
      last_rdy = r;
      if (r) begin
        idx++;
        er = step_reg(er, d, inc);
        en = step_reg(en, d, inc);
        if (!scalar && !mixed) em = step_reg(em, d, inc);
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    elem_ready = 1'b0;
    check(idx == cnt, "R3", "element count", idx, cnt);
    check(done && !elem_valid, "R12", "done after last",
          int'({done, elem_valid}), 2);
    @(negedge clk);
    check(!done && !elem_valid, "R12", "done one cycle",
          int'({done, elem_valid}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    timed_out = 1;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [4:0] sets [4][3];
    sets[0] = '{5'd3,  5'd9,  5'd20};
    sets[1] = '{5'd8,  5'd16, 5'd0};
    sets[2] = '{5'd13, 5'd27, 5'd30};
    sets[3] = '{5'd31, 5'd8,  5'd17};
    repeat (3) @(negedge clk);
    check(!elem_valid && !done && !undef, "R1", "reset outputs",
          int'({elem_valid, done, undef}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!elem_valid && !done && !undef, "R1", "idle after reset",
          int'({elem_valid, done, undef}), 0);

    for (int d = 0; d < 2; d++)
      for (int l = 0; l < 8; l++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 4; k++)
            run_op(d[0], l, s, sets[k][0], sets[k][1], sets[k][2], 1'b1, 1'b1,
                   l[0], (s == 1) && (l > 2));

    for (int d = 0; d < 2; d++)
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 4; s++)
          run_op(d[0], l, s, 5'd13, 5'd27, 5'd30, 1'b0, 1'b1, 1'b1, 1'b0);

    for (int k = 0; k < 4; k++)
      for (int h = 0; h < 2; h++)
        run_op(1'b1, 2, 2, sets[k][0], sets[k][1], sets[k][2], 1'b1, h[0],
               1'b0, 1'b0);

    if (!timed_out) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule